// File: doc/BRIEF.md
# Multichannel Scan Sequencer with Result Buffer

This block runs a burst of analog conversions when the converter is clocked from its own on-chip oscillator. A one-cycle configuration-complete pulse, accepted only while chip select is low and the clock-source bit selects the internal clock, arms the sequence. The block then turns on the oscillator and builds the channel list from a 2-bit scan code and a channel number N. It performs one conversion per channel through a start/done handshake with the converter and writes each 16-bit result into a buffer with one entry per channel.

End-of-conversion stays high while the sequence runs. After the final result is stored, end-of-conversion drops and the oscillator is turned off. The stored results are then shifted out serially, MSB first and in conversion order, with one bit per serial clock falling edge. The read-out wraps back to the first result after the last bit, so it never fills with zeros. Raising chip select at any time abandons the sequence and clears all pointers.

The design runs on a single system clock. The oscillator tick and the serial clock edge are single-cycle enables.

Top module: `scan_sequencer`

## Requirements
- R1: The scan code is on `scan_code`. Code 2'b00 performs exactly one conversion, on channel N (`chan_n`).
- R2: Code 2'b01 converts channels 0, 1, ..., N in ascending order. That is N+1 conversions.
- R3: Code 2'b10 converts channels NCH/2 through N in ascending order. When N < NCH/2, it converts only channel NCH/2, once.
- R4: Code 2'b11 converts channel N exactly NCH times.
- R5: `int_clk_sel`=1 selects the internal clock. When `int_clk_sel`=0, `cfg_done` is ignored: `osc_en` stays low and `conv_start` never pulses.
- R6: `osc_en` is high in the cycle after an accepted `cfg_done`. `conv_start` pulses only while `osc_en` is high. A new conversion is not started until `conv_done` has returned the previous one.
- R7: `eoc` stays high until the last result of the sequence is stored. It then falls in the same cycle that `osc_en` falls.
- R8: While `eoc` is low, `dout` carries the stored results in conversion order, MSB first. The MSB of the first result is present as soon as `eoc` is low, and each `sclk_fall` pulse advances one bit.
- R9: After the LSB of the last result, the next `sclk_fall` returns `dout` to the MSB of the first result, so the whole set repeats.
- R10: Chip select is active low. A rising edge on `cs_n` returns `eoc` high and `osc_en` low on the next cycle and stops all further conversions. The next sequence starts again from the first channel and the first buffer entry.
- R11: After reset, `eoc`=1, `osc_en`=0, `conv_start`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| cfg_done | input | 1 | Configuration-complete pulse |
| int_clk_sel | input | 1 | 1 = internal clock selected |
| scan_code | input | 2 | Scan pattern code |
| chan_n | input | $clog2(NCH) | Channel number N |
| osc_tick | input | 1 | Internal oscillator tick enable |
| osc_en | output | 1 | Internal oscillator enable |
| conv_start | output | 1 | Start pulse to the converter |
| conv_chan | output | $clog2(NCH) | Channel for the current conversion |
| conv_done | input | 1 | Converter result valid pulse |
| conv_data | input | DW | Converter result |
| eoc | output | 1 | End of conversion, low when results are ready |
| sclk_fall | input | 1 | Serial clock falling-edge enable |
| dout | output | 1 | Serial result data |

## Verification
Embedded assertions check the cycle-level rules on every clock. `conv_start` only occurs with the oscillator on, and never in two consecutive cycles. `eoc` falls together with the oscillator. A chip-select rise forces the idle outputs on the next cycle. A configuration pulse with the external clock selected never turns the oscillator on. The bench scenarios cover what a single cycle cannot show: the exact channel list for each scan code and N, the value and order of the shifted results, the wrap back to the first result, and the restart from the first entry after an abort.

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int NCH = 8,
  parameter int DW  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   cfg_done,
  input  logic                   int_clk_sel,
  input  logic [1:0]             scan_code,
  input  logic [$clog2(NCH)-1:0] chan_n,
  input  logic                   osc_tick,
  output logic                   osc_en,
  output logic                   conv_start,
  output logic [$clog2(NCH)-1:0] conv_chan,
  input  logic                   conv_done,
  input  logic [DW-1:0]          conv_data,
  output logic                   eoc,
  input  logic                   sclk_fall,
  output logic                   dout
);
  localparam int CHW  = $clog2(NCH);
  localparam int CNTW = $clog2(NCH + 1);
  localparam int BW   = $clog2(DW);
  localparam logic [CHW-1:0] HALF = CHW'(NCH / 2);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_READ} st_t;
  st_t st;

  logic [DW-1:0]   buffer [NCH];
  logic [CHW-1:0]  cur;
  logic            step;
  logic            waiting;
  logic [CNTW-1:0] total;
  logic [CNTW-1:0] wr_cnt;
  logic [CNTW-1:0] rd_cnt;
  logic [BW-1:0]   bit_idx;

  logic [CHW-1:0]  first_ch;
  logic [CNTW-1:0] first_total;
  logic            first_step;
  logic            accept;
  logic            last_wr;
  logic            last_bit;

  assign accept  = (st == S_IDLE) && cfg_done && int_clk_sel && !cs_n;
  assign last_wr = conv_done && waiting && (wr_cnt == total - 1'b1);
  assign last_bit = (bit_idx == BW'(DW - 1));

  always_comb begin
    first_ch    = chan_n;
    first_total = CNTW'(1);
    first_step  = 1'b0;
    case (scan_code)
      2'b01: begin
        first_ch    = '0;
        first_total = CNTW'(chan_n) + 1'b1;
        first_step  = 1'b1;
      end
      2'b10: begin
        first_ch    = HALF;
        first_total = (chan_n >= HALF) ? CNTW'(chan_n - HALF) + 1'b1 : CNTW'(1);
        first_step  = 1'b1;
      end
      2'b11: first_total = CNTW'(NCH);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cur        <= '0;
      step       <= 1'b0;
      waiting    <= 1'b0;
      total      <= '0;
      wr_cnt     <= '0;
      rd_cnt     <= '0;
      bit_idx    <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (cs_n) begin
        st      <= S_IDLE;
        waiting <= 1'b0;
        wr_cnt  <= '0;
        rd_cnt  <= '0;
        bit_idx <= '0;
      end else begin
        case (st)
          S_IDLE: if (accept) begin
            st      <= S_RUN;
            cur     <= first_ch;
            total   <= first_total;
            step    <= first_step;
            waiting <= 1'b0;
            wr_cnt  <= '0;
            rd_cnt  <= '0;
            bit_idx <= '0;
          end
          S_RUN: begin
            if (!waiting && osc_tick) begin
              conv_start <= 1'b1;
              waiting    <= 1'b1;
            end else if (waiting && conv_done) begin
              waiting <= 1'b0;
              wr_cnt  <= wr_cnt + 1'b1;
              if (step) cur <= cur + 1'b1;
              if (last_wr) st <= S_READ;
            end
          end
          S_READ: if (sclk_fall) begin
            bit_idx <= last_bit ? '0 : bit_idx + 1'b1;
            if (last_bit)
              rd_cnt <= (rd_cnt == total - 1'b1) ? '0 : rd_cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_RUN && waiting && conv_done && !cs_n)
      buffer[wr_cnt[CHW-1:0]] <= conv_data;
  end

  assign osc_en    = (st == S_RUN);
  assign eoc       = (st != S_READ);
  assign conv_chan = cur;
  assign dout      = (st == S_READ) ? buffer[rd_cnt[CHW-1:0]][BW'(DW - 1) - bit_idx] : 1'b0;

  // R6
  start_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> osc_en);
  // R6
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  // R7
  eoc_osc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc) |-> !osc_en && $past(osc_en));
  // R10
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> eoc && !osc_en && !conv_start);
  // R5
  ext_clk_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && !int_clk_sel && !osc_en && eoc) |=> !osc_en);
endmodule

// File: tb/test_scan_sequencer.sv
module test_scan_sequencer;
  localparam int NCH = 8;
  localparam int DW  = 16;
  localparam int CHW = $clog2(NCH);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, cfg_done = 1'b0, int_clk_sel = 1'b1;
  logic [1:0] scan_code = '0;
  logic [CHW-1:0] chan_n = '0;
  logic osc_tick = 1'b0, conv_done = 1'b0, sclk_fall = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic osc_en, conv_start, eoc, dout;
  logic [CHW-1:0] conv_chan;

  int checks = 0, errors = 0;
  int ncap = 0;
  logic [CHW-1:0] cap_ch [64];
  logic [DW-1:0]  cap_d  [64];
  int exp_ch [NCH];
  int exp_n;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) osc_tick <= ~osc_tick;

  scan_sequencer #(.NCH(NCH), .DW(DW)) i_scan_sequencer (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cfg_done(cfg_done), .int_clk_sel(int_clk_sel),
    .scan_code(scan_code), .chan_n(chan_n), .osc_tick(osc_tick), .osc_en(osc_en),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_data(conv_data), .eoc(eoc), .sclk_fall(sclk_fall), .dout(dout));

  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        cap_ch[ncap % 64] = conv_chan;
        cap_d[ncap % 64]  = DW'($urandom);
        conv_data = cap_d[ncap % 64];
        ncap++;
        repeat (3) @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic void build_list(input logic [1:0] code, input int n);
    exp_n = 0;
    case (code)
      2'b00: begin exp_ch[0] = n; exp_n = 1; end
      2'b01: for (int c = 0; c <= n; c++) exp_ch[exp_n++] = c;
      2'b10: if (n < NCH/2) begin exp_ch[0] = NCH/2; exp_n = 1; end
             else for (int c = NCH/2; c <= n; c++) exp_ch[exp_n++] = c;
      default: for (int k = 0; k < NCH; k++) exp_ch[exp_n++] = n;
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] code);
    case (code)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic run_scan(input logic [1:0] code, input int n);
    int base;
    int tmo;
    logic [DW-1:0] word;
    base = ncap;
    build_list(code, n);
    @(negedge clk);
    cs_n = 1'b0; int_clk_sel = 1'b1; scan_code = code; chan_n = CHW'(n);
    cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
    check("R6 osc_en after cfg_done", osc_en, 1);
    check("R7 eoc high while running", eoc, 1);
    tmo = 0;
    while (eoc && tmo < 3000) begin @(negedge clk); tmo++; end
    check("R7 eoc fell", eoc, 0);
    check("R7 osc off at eoc fall", osc_en, 0);
    check({req_of(code), " conversion count"}, ncap - base, exp_n);
    for (int i = 0; i < exp_n; i++)
      check({req_of(code), " channel order"}, cap_ch[(base + i) % 64], exp_ch[i]);
    for (int p = 0; p < 2; p++)
      for (int w = 0; w < exp_n; w++) begin
        for (int b = DW - 1; b >= 0; b--) begin
          word[b] = dout;
          sclk_fall = 1'b1;
          @(negedge clk);
        end
        check(p == 0 ? "R8 read-out word" : "R9 wrapped word", word, cap_d[(base + w) % 64]);
      end
    sclk_fall = 1'b0;
    cs_n = 1'b1;
    @(negedge clk);
    check("R10 eoc high after cs rise", eoc, 1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11 eoc", eoc, 1);
    check("R11 osc_en", osc_en, 0);
    check("R11 conv_start", conv_start, 0);
    check("R11 dout", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: external clock selected
    cs_n = 1'b0; int_clk_sel = 1'b0; scan_code = 2'b01; chan_n = 3'd7;
    held = ncap;
    cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
    check("R5 osc_en", osc_en, 0);
    repeat (20) @(negedge clk);
    check("R5 no conversions", ncap - held, 0);
    check("R5 eoc", eoc, 1);
    cs_n = 1'b1;
    @(negedge clk);

    run_scan(2'b00, 5);
    run_scan(2'b01, 7);
    run_scan(2'b01, 0);
    run_scan(2'b10, 2);
    run_scan(2'b10, 7);
    run_scan(2'b11, 3);

    // R10: abort mid-sequence
    cs_n = 1'b0; int_clk_sel = 1'b1; scan_code = 2'b01; chan_n = 3'd7;
    held = ncap;
    cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
    while (ncap - held < 3) @(negedge clk);
    cs_n = 1'b1;
    held = ncap;
    @(negedge clk);
    check("R10 osc off after abort", osc_en, 0);
    check("R10 eoc high after abort", eoc, 1);
    repeat (30) @(negedge clk);
    check("R10 no conversions after abort", ncap - held, 0);
    run_scan(2'b01, 4);

    for (int t = 0; t < 20; t++)
      run_scan(2'($urandom), int'($urandom % NCH));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule